// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a byte-addressed serial memory. It watches the two bus lines (SCL and SDA) with the system clock and finds START and STOP conditions. It shifts in a control byte, checks the device code and the three strap-selected address bits, and collects a two-byte word address. It then acknowledges write data or streams read data back. Incoming lines pass through a short synchronizer, and all decisions are made on edges of the synchronized SCL. The block does not drive SDA high. It raises a pull-low enable, and an open-drain pad outside turns that into the bus level.

Write bytes do not go to the storage here. Each accepted byte leaves on a one-cycle handoff strobe with its address. When the transaction ends with STOP and at least one byte was handed off, the block gives a one-cycle commit pulse. A separate write-cache block consumes both and reports back through a busy flag. While that flag is high the engine acknowledges nothing, so a master can poll the device until its write finishes. Reads use a combinational byte-wide array read port addressed by the internal pointer. The same pointer serves reads and writes. It is 13 bits wide, so it runs past the 4096-byte storage into a void region and never wraps back to zero.

Top module: `twi_mem_slave`

## Requirements
- R1: After synchronous reset the pull-low enable is released, no handoff or commit strobe is raised, and the address pointer is 0.
- R2: A control byte is accepted only when its upper nibble is 4'b1010 and bits 3..1 equal `strap_i`; bit 0 selects read (1) or write (0). A rejected control byte gets no acknowledge, and every further byte is refused until the next START or STOP.
- R3: For an accepted byte, the pull-low enable goes high after the SCL fall that ends the eighth bit and is held through the whole ninth (acknowledge) clock. It is released at the SCL fall that ends that clock.
- R4: After a write control byte come two address bytes, high byte first and MSB first. The pointer loads {1'b0, high[3:0], low} when the low byte is acknowledged. A high byte whose bits 7..4 are not all zero is refused, and the pointer keeps its value.
- R5: Every accepted write data byte is handed off on `wr_valid_o` with the current pointer as its address, and then the pointer advances by one.
- R6: While `busy_i` is high at the end of any received byte, including the control byte, no acknowledge is given and the rest of the transaction is ignored.
- R7: A read control byte with no address phase returns the byte at the current pointer, MSB first. The first bit is driven after the SCL fall that ends the acknowledge slot, and the pointer advances by one per byte sent.
- R8: A random read keeps the pointer loaded by an address-only write that ends in a repeated START followed by a read control byte.
- R9: In a read, a master acknowledge (SDA low in the ninth clock) makes the block send the next sequential byte. A master non-acknowledge releases SDA and the block waits for START or STOP.
- R10: The pointer does not wrap from 0xFFF to 0. Addresses with bit 12 set read as 8'hFF, and write bytes there are acknowledged but never handed off.
- R11: `commit_o` pulses for one cycle after a STOP only if at least one byte was handed off since the previous STOP. A STOP after reads or address-only writes gives no pulse.
- R12: A START or STOP at any point, including mid-byte, aborts the byte in progress and releases SDA. After a START the next byte is treated as a control byte.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved wire) |
| strap_i | input | 3 | Device-select straps compared with control bits 3..1 |
| busy_i | input | 1 | Write cache is running an internal write cycle |
| mem_rdata_i | input | 8 | Array read data for `mem_raddr_o` (combinational) |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |
| mem_raddr_o | output | 12 | Array read address (low bits of the pointer) |
| wr_valid_o | output | 1 | One-cycle strobe: a write byte is handed off |
| wr_addr_o | output | 12 | Address of the handed-off byte |
| wr_data_o | output | 8 | Handed-off write byte |
| commit_o | output | 1 | One-cycle pulse: STOP closed a transaction with handed-off data |

## Verification
Directed transactions cover the cases that separate a correct engine from a near miss: a wrong strap value or wrong code (is the control byte decoded?), a nonzero upper address nibble, busy arriving before the control byte and between bytes, and a START or STOP cut into a half-sent byte. Writes and reads that straddle 0xFFF show whether the pointer wraps or runs on into the void region. Random write bursts at random addresses and lengths, each read back through a random address then sequential read, check pointer bookkeeping across the whole array. Current-address reads after each scenario show the pointer value directly.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

    localparam int          BYTE_W    = 8;
    localparam int          CNT_W     = 4;
    localparam logic [3:0]  DEV_CODE  = 4'b1010;
    localparam logic [7:0]  VOID_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_MACK,
        S_WAIT
    } eng_state_e;

    typedef enum logic [1:0] {
        PH_CTRL,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } rx_phase_e;

    // Events seen on the synchronized bus lines, one cycle wide.
    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    function automatic rx_phase_e phase_after(rx_phase_e p);
        case (p)
            PH_CTRL: return PH_AHI;
            PH_AHI:  return PH_ALO;
            default: return PH_DATA;
        endcase
    endfunction

    // Bytes beyond the implemented storage read as all ones.
    function automatic logic [BYTE_W-1:0] fetch_byte(logic beyond, logic [BYTE_W-1:0] d);
        return beyond ? VOID_BYTE : d;
    endfunction

endpackage

// File: rtl/twi_line_mon.sv
module twi_line_mon
    import twi_mem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    always_comb begin
        ev_o.rise  = scl_s & ~scl_d;
        ev_o.fall  = ~scl_s & scl_d;
        ev_o.start = scl_s & scl_d & sda_d & ~sda_s;
        ev_o.stop  = scl_s & scl_d & ~sda_d & sda_s;
        ev_o.sda   = sda_s;
    end

endmodule

// File: rtl/twi_mem_ptr.sv
module twi_mem_ptr #(
    parameter int PTR_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [PTR_W-1:0] load_val_i,
    input  logic             inc_i,
    output logic [PTR_W-1:0] ptr_o
);
    always_ff @(posedge clk) begin
        if (rst)         ptr_o <= '0;
        else if (load_i) ptr_o <= load_val_i;
        else if (inc_i)  ptr_o <= ptr_o + 1'b1;
    end

endmodule

// File: rtl/twi_mem_engine.sv
module twi_mem_engine
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              pull_o,
    output logic              ptr_load_o,
    output logic [PTR_W-1:0]  ptr_val_o,
    output logic              ptr_inc_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              commit_o
);
    localparam int HI_W = ADDR_W - BYTE_W;

    eng_state_e        state;
    rx_phase_e         phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [HI_W-1:0]   hi_q;
    logic              rd_mode, mack_q, pull_q, wr_seen, wr_valid_q, commit_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [BYTE_W-1:0] wr_data_q;

    logic              byte_end, ctrl_hit, fmt_ok, accept, beyond, tx_load;
    logic [BYTE_W-1:0] next_byte;

    assign byte_end  = (state == S_RX) && ev.fall && (bit_cnt == 4'd8);
    assign ctrl_hit  = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == strap_i);
    assign beyond    = ptr_i[PTR_W-1];
    assign next_byte = fetch_byte(beyond, rdata_i);
    assign tx_load   = ev.fall && (((state == S_ACK) && rd_mode) ||
                                   ((state == S_MACK) && !mack_q));

    always_comb begin
        case (phase)
            PH_CTRL: fmt_ok = ctrl_hit;
            PH_AHI:  fmt_ok = (shreg[BYTE_W-1:HI_W] == '0);
            default: fmt_ok = 1'b1;
        endcase
    end

    assign accept     = !busy_i && fmt_ok;
    assign ptr_load_o = byte_end && accept && (phase == PH_ALO);
    assign ptr_val_o  = {1'b0, hi_q, shreg};
    assign ptr_inc_o  = tx_load || (byte_end && accept && (phase == PH_DATA));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            phase      <= PH_CTRL;
            bit_cnt    <= '0;
            shreg      <= '0;
            hi_q       <= '0;
            rd_mode    <= 1'b0;
            mack_q     <= 1'b1;
            pull_q     <= 1'b0;
            wr_seen    <= 1'b0;
            wr_valid_q <= 1'b0;
            commit_q   <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
        end else begin
            wr_valid_q <= 1'b0;
            commit_q   <= 1'b0;
            if (ev.stop) begin
                state    <= S_IDLE;
                pull_q   <= 1'b0;
                commit_q <= wr_seen;
                wr_seen  <= 1'b0;
            end else if (ev.start) begin
                state   <= S_RX;
                phase   <= PH_CTRL;
                bit_cnt <= '0;
                pull_q  <= 1'b0;
                rd_mode <= 1'b0;
            end else begin
                case (state)
                    S_RX: begin
                        if (ev.rise && (bit_cnt != 4'd8)) begin
                            shreg   <= {shreg[BYTE_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_end) begin
                            if (accept) begin
                                state  <= S_ACK;
                                pull_q <= 1'b1;
                                phase  <= phase_after(phase);
                                if (phase == PH_CTRL) rd_mode <= shreg[0];
                                if (phase == PH_AHI)  hi_q <= shreg[HI_W-1:0];
                                if ((phase == PH_DATA) && !beyond) begin
                                    wr_valid_q <= 1'b1;
                                    wr_seen    <= 1'b1;
                                    wr_addr_q  <= ptr_i[ADDR_W-1:0];
                                    wr_data_q  <= shreg;
                                end
                            end else begin
                                state <= S_WAIT;
                            end
                        end
                    end
                    S_ACK: begin
                        if (ev.fall) begin
                            bit_cnt <= '0;
                            if (rd_mode) begin
                                state  <= S_TX;
                                shreg  <= next_byte;
                                pull_q <= ~next_byte[BYTE_W-1];
                            end else begin
                                state  <= S_RX;
                                pull_q <= 1'b0;
                            end
                        end
                    end
                    S_TX: begin
                        if (ev.fall) begin
                            if (bit_cnt == 4'd7) begin
                                state  <= S_MACK;
                                pull_q <= 1'b0;
                            end else begin
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                                pull_q  <= ~shreg[BYTE_W-2];
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    S_MACK: begin
                        if (ev.rise) mack_q <= ev.sda;
                        if (ev.fall) begin
                            if (!mack_q) begin
                                state   <= S_TX;
                                bit_cnt <= '0;
                                shreg   <= next_byte;
                                pull_q  <= ~next_byte[BYTE_W-1];
                            end else begin
                                state <= S_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pull_o     = pull_q;
    assign wr_valid_o = wr_valid_q;
    assign wr_addr_o  = wr_addr_q;
    assign wr_data_o  = wr_data_q;
    assign commit_o   = commit_q;

    // R3
    pull_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pull_q) |-> $past(ev.fall));

    // R6
    busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_end && busy_i) |=> (!pull_q && (state == S_WAIT)));

    // R12
    cond_release_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.start || ev.stop) |=> !pull_q);

    // R11
    commit_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        commit_q |-> $past(ev.stop));

    // R5
    handoff_step_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid_q |-> (ptr_i == ({1'b0, wr_addr_q} + 1'b1)));

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    input  logic [7:0]        mem_rdata_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] mem_raddr_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              commit_o
);
    localparam int PTR_W = ADDR_W + 1;

    line_ev_t         ev;
    logic [PTR_W-1:0] ptr, ptr_val;
    logic             ptr_load, ptr_inc;

    twi_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    twi_mem_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ptr_load),
        .load_val_i (ptr_val),
        .inc_i      (ptr_inc),
        .ptr_o      (ptr)
    );

    twi_mem_engine #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .strap_i    (strap_i),
        .busy_i     (busy_i),
        .ptr_i      (ptr),
        .rdata_i    (mem_rdata_i),
        .pull_o     (sda_pull_o),
        .ptr_load_o (ptr_load),
        .ptr_val_o  (ptr_val),
        .ptr_inc_o  (ptr_inc),
        .wr_valid_o (wr_valid_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .commit_o   (commit_o)
    );

    assign mem_raddr_o = ptr[ADDR_W-1:0];

endmodule

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;

    localparam int Q = 4;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic        busy = 1'b0;
    logic        sda_pull, wr_valid, commit, sda_line;
    logic [11:0] mem_raddr, wr_addr;
    logic [7:0]  wr_data, mem_rdata;

    logic [7:0]  arr [0:4095];
    logic [7:0]  wbuf [0:7];
    logic [11:0] cap_a [0:63];
    logic [7:0]  cap_d [0:63];
    int          cap_n = 0, commit_n = 0;
    int          n_chk = 0, n_bad = 0;
    logic [12:0] exp_ptr = '0;

    always #10 clk = ~clk;

    assign sda_line  = sda_m & ~sda_pull;
    assign mem_rdata = arr[mem_raddr];

    twi_mem_slave dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .strap_i     (strap),
        .busy_i      (busy),
        .mem_rdata_i (mem_rdata),
        .sda_pull_o  (sda_pull),
        .mem_raddr_o (mem_raddr),
        .wr_valid_o  (wr_valid),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .commit_o    (commit)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid) begin
                cap_a[cap_n % 64] = wr_addr;
                cap_d[cap_n % 64] = wr_data;
                cap_n++;
            end
            if (commit) commit_n++;
        end
    end

    function automatic logic [7:0] ctrl(bit rd, logic [2:0] sel);
        return {4'b1010, sel, rd};
    endfunction

    function automatic logic [7:0] exp_read(logic [12:0] p);
        return p[12] ? 8'hFF : arr[p[11:0]];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0; tick(Q);
        end
    endtask

    // acked is set only if SDA stays low in the middle and at the end of the ninth clock
    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit a0;
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(2);
        a0 = (sda_line == 1'b0);
        tick(H - 3);
        acked = a0 && (sda_line == 1'b0);
        tick(1);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(H / 2);
            b[i] = sda_line;
            tick(H / 2);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = mack ? 1'b0 : 1'b1; tick(Q);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic set_addr(input logic [11:0] a, input string req);
        bit ack;
        bus_start();
        send_byte(ctrl(0, strap), ack); chk(ack, req, ack, 1);
        send_byte({4'b0000, a[11:8]}, ack); chk(ack, req, ack, 1);
        send_byte(a[7:0], ack); chk(ack, req, ack, 1);
        exp_ptr = {1'b0, a};
    endtask

    // R5 R10 R11: write n bytes from wbuf starting at a
    task automatic write_run(input logic [11:0] a, input int n);
        bit ack;
        int base, cbase, want;
        logic [12:0] p;
        base = cap_n; cbase = commit_n; want = 0;
        set_addr(a, "R4");
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack);
            chk(ack, "R5 data ack", ack, 1);
        end
        bus_stop();
        tick(4);
        for (int k = 0; k < n; k++) begin
            p = {1'b0, a} + 13'(k);
            if (!p[12]) begin
                chk(cap_a[(base + want) % 64] == p[11:0], "R5 handoff addr", cap_a[(base + want) % 64], p[11:0]);
                chk(cap_d[(base + want) % 64] == wbuf[k], "R5 handoff data", cap_d[(base + want) % 64], wbuf[k]);
                arr[p[11:0]] = wbuf[k];
                want++;
            end
        end
        chk((cap_n - base) == want, "R10 handoff count", cap_n - base, want);
        chk((commit_n - cbase) == ((want > 0) ? 1 : 0), "R11 commit", commit_n - cbase, (want > 0) ? 1 : 0);
        exp_ptr = {1'b0, a} + 13'(n);
    endtask

    // R7 R8 R9: optional address phase, repeated START, n-byte read
    task automatic read_run(input bit use_addr, input logic [11:0] a, input int n, input string req);
        bit ack;
        logic [7:0] b;
        int cbase;
        cbase = commit_n;
        if (use_addr) set_addr(a, "R8 addr");
        bus_start();
        send_byte(ctrl(1, strap), ack);
        chk(ack, req, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            chk(b == exp_read(exp_ptr), req, b, exp_read(exp_ptr));
            exp_ptr = exp_ptr + 1'b1;
        end
        chk(sda_pull == 1'b0, "R9 release after NACK", sda_pull, 0);
        bus_stop();
        tick(4);
        chk(commit_n == cbase, "R11 no commit on read", commit_n - cbase, 0);
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] b;
        int cb;
        void'($urandom(32'd2024));
        for (int i = 0; i < 4096; i++) arr[i] = 8'((i * 37 + 11) ^ (i >> 4));

        tick(5);
        chk(sda_pull == 1'b0, "R1 pull released", sda_pull, 0);
        chk(wr_valid == 1'b0, "R1 no handoff", wr_valid, 0);
        chk(commit == 1'b0, "R1 no commit", commit, 0);
        rst = 1'b0;
        tick(4);
        read_run(0, 12'h0, 1, "R1 pointer zero");

        // R2 wrong straps and wrong code
        cb = cap_n;
        bus_start();
        send_byte(ctrl(0, 3'b100), ack); chk(!ack, "R2 strap mismatch", ack, 0);
        send_byte(8'h00, ack); chk(!ack, "R2 ignore rest", ack, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, strap, 1'b0}, ack); chk(!ack, "R2 code mismatch", ack, 0);
        bus_stop();
        tick(4);
        chk(cap_n == cb, "R2 no handoff", cap_n - cb, 0);

        // R3 R4 directed write with release check
        bus_start();
        send_byte(ctrl(0, strap), ack); chk(ack, "R2 match ack", ack, 1);
        send_byte(8'h01, ack); chk(ack, "R4 high ack", ack, 1);
        send_byte(8'h23, ack); chk(ack, "R3 ack held", ack, 1);
        chk(sda_pull == 1'b0, "R3 released after ninth clock", sda_pull, 0);
        bus_stop();
        exp_ptr = 13'h123;
        read_run(0, 12'h0, 1, "R4 pointer load");

        // R4 bad high byte keeps pointer
        bus_start();
        send_byte(ctrl(0, strap), ack); chk(ack, "R4 ctrl", ack, 1);
        send_byte(8'h31, ack); chk(!ack, "R4 nonzero nibble", ack, 0);
        bus_stop();
        read_run(0, 12'h0, 1, "R4 pointer kept");

        // R6 busy between bytes and on the control byte
        bus_start();
        send_byte(ctrl(0, strap), ack); chk(ack, "R6 ctrl idle", ack, 1);
        busy = 1'b1;
        send_byte(8'h00, ack); chk(!ack, "R6 busy mid", ack, 0);
        bus_stop();
        bus_start();
        send_byte(ctrl(0, strap), ack); chk(!ack, "R6 poll busy", ack, 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(ctrl(0, strap), ack); chk(ack, "R6 poll done", ack, 1);
        bus_stop();
        read_run(0, 12'h0, 1, "R6 pointer kept");

        // R7 R8 R9
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
        write_run(12'h200, 2);
        read_run(0, 12'h0, 1, "R7 current read");
        read_run(1, 12'h200, 1, "R8 random read");
        read_run(1, 12'h7FC, 5, "R9 sequential");

        // R10 top of storage
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        write_run(12'hFFE, 3);
        read_run(0, 12'h0, 2, "R10 void read");
        read_run(1, 12'hFFF, 2, "R10 no wrap");

        // R11 address-only write gives no commit
        cb = commit_n;
        set_addr(12'h040, "R11 addr");
        bus_stop();
        tick(4);
        chk(commit_n == cb, "R11 no commit address only", commit_n - cb, 0);

        // R12 abort mid-byte with START, then with STOP
        cb = cap_n;
        bus_start();
        send_bits(8'hA0, 4);
        bus_start();
        send_byte(ctrl(0, strap), ack); chk(ack, "R12 restart ctrl", ack, 1);
        send_byte(8'h00, ack); chk(ack, "R12 high", ack, 1);
        send_byte(8'h40, ack); chk(ack, "R12 low", ack, 1);
        send_bits(8'hFF, 3);
        bus_stop();
        tick(4);
        chk(sda_pull == 1'b0, "R12 released", sda_pull, 0);
        chk(cap_n == cb, "R12 partial byte dropped", cap_n - cb, 0);
        exp_ptr = 13'h040;
        read_run(0, 12'h0, 1, "R12 pointer after abort");

        // random bursts
        for (int it = 0; it < 12; it++) begin
            logic [11:0] a;
            int n;
            a = 12'($urandom_range(0, 4095));
            n = $urandom_range(1, 6);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            write_run(a, n);
            read_run(1, a, n, "R9 random readback");
        end

        report();
        $finish;
    end

endmodule